// File: doc/BRIEF.md
# Stripe and Gradation Test Pattern Generator

This block sits after the per-channel conversion path of an imaging front end and can substitute synthetic 12-bit pixel codes for the converted data. It is used to check the downstream data path without a sensor signal. When test mode is off, each channel's live code is registered and passed on. When test mode is on, every channel carries the same synthetic code.

Two patterns are available. The stripe pattern alternates between the programmed black level and that level raised by 128. The gradation pattern is a ramp that climbs one code at a time from 1 to 4095. A 2-bit interval field sets both the stripe width and the ramp step interval. All pattern state advances only on the pixel strobe, and a line-start pulse restarts both patterns.

The pattern counters run on every strobe whatever the enable and select inputs are. Switching pattern or enabling test mode partway through a line therefore shows the selected pattern at its position within the current line.

Top module: `test_pattern_gen`

## Requirements
- R1: After reset, `out_valid` is 0 on every channel and every `out_code` is 0.
- R2: With `tp_enable` = 0, a pixel strobe in one cycle makes `out_valid` 1 in the next cycle, and that channel's `out_code` equals the channel's `live_code` as sampled with the strobe. `out_valid` is 0 in the cycle after a cycle with no strobe.
- R3: The black level is twice `clamp_code` (0x50 gives 160). The stripe high level is the black level plus 128, saturated at 4095.
- R4: With `tp_enable` = 1 and `tp_stripe_sel` = 1, pixel k of a line (k = 0 at the line-start pixel) carries the high level when floor(k / W) is even and the black level when it is odd. W is 8, 16, 32 or 64 for `interval_sel` = 0, 1, 2 or 3.
- R5: With `tp_enable` = 1 and `tp_stripe_sel` = 0, pixel k of a line carries 1 + floor(k / S). S is 2, 4, 8 or 16 for `interval_sel` = 0, 1, 2 or 3.
- R6: The gradation code that follows 4095 is 1, so the code equals 1 + (floor(k / S) mod 4095).
- R7: Cycles without a strobe do not advance either pattern, and they leave `out_code` unchanged.
- R8: A `line_start` pulse given with a strobe makes that pixel k = 0 for both patterns, even in the middle of a line.
- R9: Both pattern counters advance on every strobe, whatever `tp_enable` and `tp_stripe_sel` are. Changing the select in the middle of a line gives the newly selected pattern at the current k. In test mode all channels carry the same code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pix_stb | input | 1 | One-cycle strobe per pixel |
| line_start | input | 1 | Marks the first pixel of a line; restarts both patterns |
| tp_enable | input | 1 | 1 = output test pattern, 0 = pass live data |
| tp_stripe_sel | input | 1 | 1 = stripe pattern, 0 = gradation pattern |
| interval_sel | input | 2 | Stripe width and ramp step interval select |
| clamp_code | input | 8 | Black-level code; level = 2 x code |
| live_code | input | 24 | Live codes; channel n occupies bits [12n+11:12n] |
| out_code | output | 24 | Output codes, packed like `live_code` |
| out_valid | output | 2 | Per-channel valid, one cycle after each strobe |

## Verification
The hardest state to reach is the ramp wrap from 4095 back to 1. It needs 8190 strobes at the shortest step interval with no line start in between, so the bench drives one unbroken line of 8200 back-to-back pixels and checks every code across the wrap. Strobe gaps are put into the stripe sweeps, and both pattern counters are held free-running across a mid-line pattern switch. Together these show that the pattern position depends only on the count of strobes since the last line start.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  typedef enum logic {
    PAT_RAMP   = 1'b0,
    PAT_STRIPE = 1'b1
  } pat_sel_e;
endpackage

// File: rtl/tpg_stripe_gen.sv
module tpg_stripe_gen #(
  parameter int PIX_W   = 12,
  parameter int CLAMP_W = 8,
  parameter int ISEL_W  = 2,
  parameter int LOG_MIN = 3,
  parameter int STEP    = 128
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pix_stb,
  input  logic               line_start,
  input  logic [ISEL_W-1:0]  interval_sel,
  input  logic [CLAMP_W-1:0] clamp_code,
  output logic [PIX_W-1:0]   code
);
  localparam int CW = LOG_MIN + (1 << ISEL_W) - 1;

  logic [CW-1:0]    cnt_q, cnt_d, eff_cnt, limit;
  logic [CW:0]      lim_full;
  logic             hi_q, hi_d, eff_hi;
  logic [PIX_W:0]   black_ext, hi_sum;
  logic [PIX_W-1:0] black_lvl, hi_lvl;

  // black level is twice the clamp code; the raised level saturates
  always_comb begin
    black_ext = (PIX_W+1)'({clamp_code, 1'b0});
    hi_sum    = black_ext + (PIX_W+1)'(STEP);
    black_lvl = black_ext[PIX_W-1:0];
    hi_lvl    = hi_sum[PIX_W] ? '1 : hi_sum[PIX_W-1:0];
  end

  always_comb begin
    lim_full = ((CW+1)'(1) << (LOG_MIN + int'(interval_sel))) - (CW+1)'(1);
    limit    = lim_full[CW-1:0];
    eff_cnt  = line_start ? '0 : cnt_q;
    eff_hi   = line_start ? 1'b1 : hi_q;
    cnt_d    = cnt_q;
    hi_d     = hi_q;
    if (pix_stb) begin
      if (eff_cnt >= limit) begin
        cnt_d = '0;
        hi_d  = ~eff_hi;
      end else begin
        cnt_d = eff_cnt + CW'(1);
        hi_d  = eff_hi;
      end
    end else if (line_start) begin
      cnt_d = '0;
      hi_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      hi_q  <= 1'b1;
    end else if (pix_stb || line_start) begin
      cnt_q <= cnt_d;
      hi_q  <= hi_d;
    end
  end

  assign code = eff_hi ? hi_lvl : black_lvl;
endmodule

// File: rtl/tpg_ramp_gen.sv
module tpg_ramp_gen #(
  parameter int PIX_W   = 12,
  parameter int ISEL_W  = 2,
  parameter int LOG_MIN = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_stb,
  input  logic              line_start,
  input  logic [ISEL_W-1:0] interval_sel,
  output logic [PIX_W-1:0]  code
);
  localparam int CW = LOG_MIN + (1 << ISEL_W) - 1;
  localparam logic [PIX_W-1:0] START = PIX_W'(1);

  logic [CW-1:0]    cnt_q, cnt_d, eff_cnt, limit;
  logic [CW:0]      lim_full;
  logic [PIX_W-1:0] val_q, val_d, eff_val;

  always_comb begin
    lim_full = ((CW+1)'(1) << (LOG_MIN + int'(interval_sel))) - (CW+1)'(1);
    limit    = lim_full[CW-1:0];
    eff_cnt  = line_start ? '0 : cnt_q;
    eff_val  = line_start ? START : val_q;
    cnt_d    = cnt_q;
    val_d    = val_q;
    if (pix_stb) begin
      if (eff_cnt >= limit) begin
        cnt_d = '0;
        val_d = (eff_val == '1) ? START : eff_val + PIX_W'(1);
      end else begin
        cnt_d = eff_cnt + CW'(1);
        val_d = eff_val;
      end
    end else if (line_start) begin
      cnt_d = '0;
      val_d = START;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      val_q <= START;
    end else if (pix_stb || line_start) begin
      cnt_q <= cnt_d;
      val_q <= val_d;
    end
  end

  assign code = eff_val;
endmodule

// File: rtl/tpg_chan_out.sv
module tpg_chan_out #(
  parameter int PIX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_stb,
  input  logic             tp_enable,
  input  logic [PIX_W-1:0] pat_code,
  input  logic [PIX_W-1:0] live_code,
  output logic [PIX_W-1:0] out_code,
  output logic             out_valid
);
  logic [PIX_W-1:0] code_d;

  always_comb code_d = tp_enable ? pat_code : live_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_code  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= pix_stb;
      if (pix_stb) out_code <= code_d;
    end
  end
endmodule

// File: rtl/test_pattern_gen.sv
module test_pattern_gen
  import tpg_pkg::*;
#(
  parameter int PIX_W      = 12,
  parameter int NCH        = 2,
  parameter int CLAMP_W    = 8,
  parameter int ISEL_W     = 2,
  parameter int STRIPE_LOG = 3,
  parameter int RAMP_LOG   = 1,
  parameter int STRIPE_AMP = 128
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pix_stb,
  input  logic                 line_start,
  input  logic                 tp_enable,
  input  logic                 tp_stripe_sel,
  input  logic [ISEL_W-1:0]    interval_sel,
  input  logic [CLAMP_W-1:0]   clamp_code,
  input  logic [NCH*PIX_W-1:0] live_code,
  output logic [NCH*PIX_W-1:0] out_code,
  output logic [NCH-1:0]       out_valid
);
  logic [1:0]       rst_sync;
  logic             rst_sync_n;
  logic [PIX_W-1:0] stripe_code, ramp_code, pat_code;
  pat_sel_e         pat_sel;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  tpg_stripe_gen #(
    .PIX_W(PIX_W), .CLAMP_W(CLAMP_W), .ISEL_W(ISEL_W),
    .LOG_MIN(STRIPE_LOG), .STEP(STRIPE_AMP)
  ) u_stripe (
    .clk(clk), .rst_n(rst_sync_n), .pix_stb(pix_stb), .line_start(line_start),
    .interval_sel(interval_sel), .clamp_code(clamp_code), .code(stripe_code)
  );

  tpg_ramp_gen #(
    .PIX_W(PIX_W), .ISEL_W(ISEL_W), .LOG_MIN(RAMP_LOG)
  ) u_ramp (
    .clk(clk), .rst_n(rst_sync_n), .pix_stb(pix_stb), .line_start(line_start),
    .interval_sel(interval_sel), .code(ramp_code)
  );

  always_comb begin
    pat_sel  = pat_sel_e'(tp_stripe_sel);
    pat_code = (pat_sel == PAT_STRIPE) ? stripe_code : ramp_code;
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    tpg_chan_out #(.PIX_W(PIX_W)) u_out (
      .clk(clk), .rst_n(rst_sync_n), .pix_stb(pix_stb), .tp_enable(tp_enable),
      .pat_code(pat_code), .live_code(live_code[ch*PIX_W +: PIX_W]),
      .out_code(out_code[ch*PIX_W +: PIX_W]), .out_valid(out_valid[ch])
    );
  end
endmodule

// File: rtl/tpg_checker.sv
module tpg_checker #(
  parameter int PIX_W   = 12,
  parameter int NCH     = 2,
  parameter int CLAMP_W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 pix_stb,
  input logic                 line_start,
  input logic                 tp_enable,
  input logic                 tp_stripe_sel,
  input logic [CLAMP_W-1:0]   clamp_code,
  input logic [NCH*PIX_W-1:0] live_code,
  input logic [NCH*PIX_W-1:0] out_code,
  input logic [NCH-1:0]       out_valid
);
  localparam int MAXC = (1 << PIX_W) - 1;

  int unsigned hi_exp;
  always_comb begin
    hi_exp = 2 * int'(clamp_code) + 128;
    if (hi_exp > MAXC) hi_exp = MAXC;
  end

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pix_stb |=> (out_valid == '1));

  p_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_stb |=> (out_valid == '0));

  p_pass_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_stb && !tp_enable) |=> (out_code == $past(live_code)));

  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_stb |=> $stable(out_code));

  p_stripe_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_stb && line_start && tp_enable && tp_stripe_sel) |=>
      (32'(out_code[PIX_W-1:0]) == $past(hi_exp)));

  p_ramp_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_stb && line_start && tp_enable && !tp_stripe_sel) |=>
      (out_code[PIX_W-1:0] == PIX_W'(1)));

  p_ramp_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_stb && tp_enable && !tp_stripe_sel) |=> (out_code[PIX_W-1:0] != '0));

  for (genvar ch = 1; ch < NCH; ch++) begin : g_same
    p_chan_equal_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_stb && tp_enable) |=>
        (out_code[ch*PIX_W +: PIX_W] == out_code[PIX_W-1:0]));
  end
endmodule

bind test_pattern_gen tpg_checker #(
  .PIX_W(PIX_W), .NCH(NCH), .CLAMP_W(CLAMP_W)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .pix_stb(pix_stb), .line_start(line_start),
  .tp_enable(tp_enable), .tp_stripe_sel(tp_stripe_sel), .clamp_code(clamp_code),
  .live_code(live_code), .out_code(out_code), .out_valid(out_valid)
);

// File: tb/test_pattern_gen_tb.sv
module test_pattern_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 12;
  localparam int NC = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          pix_stb, line_start, tp_enable, tp_stripe_sel;
  logic [1:0]    interval_sel;
  logic [7:0]    clamp_code;
  logic [NC*PW-1:0] live_code, out_code;
  logic [NC-1:0] out_valid;

  int n_chk = 0;
  int n_fail = 0;
  int k = 0;
  int seq = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  test_pattern_gen u_dut (
    .clk(clk), .rst_n(rst_n), .pix_stb(pix_stb), .line_start(line_start),
    .tp_enable(tp_enable), .tp_stripe_sel(tp_stripe_sel), .interval_sel(interval_sel),
    .clamp_code(clamp_code), .live_code(live_code), .out_code(out_code),
    .out_valid(out_valid)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_pat(input int kk, input bit stripe, input int sel, input int clamp);
    int blk, hi;
    if (stripe) begin
      blk = 2 * clamp;
      hi  = blk + 128;
      if (hi > 4095) hi = 4095;
      return (((kk >> (3 + sel)) & 1) == 0) ? hi : blk;
    end
    return 1 + ((kk >> (1 + sel)) % 4095);
  endfunction

  // one pixel: strobe for one cycle, check the registered result, then idle
  task automatic px(input bit ls, input int idle, input string tag);
    int e0, e1;
    logic [NC*PW-1:0] held;
    @(negedge clk);
    if (ls) k = 0;
    seq++;
    live_code  = {PW'((seq * 13 + 700) % 4096), PW'((seq * 37 + 11) % 4096)};
    line_start = ls;
    pix_stb    = 1'b1;
    if (tp_enable) begin
      e0 = exp_pat(k, tp_stripe_sel, int'(interval_sel), int'(clamp_code));
      e1 = e0;
    end else begin
      e0 = int'(live_code[PW-1:0]);
      e1 = int'(live_code[2*PW-1:PW]);
    end
    @(negedge clk);
    pix_stb    = 1'b0;
    line_start = 1'b0;
    chk(out_valid == 2'b11, tag, int'(out_valid), 3);
    chk(int'(out_code[PW-1:0]) == e0, tag, int'(out_code[PW-1:0]), e0);
    chk(int'(out_code[2*PW-1:PW]) == e1, tag, int'(out_code[2*PW-1:PW]), e1);
    held = out_code;
    k++;
    for (int i = 0; i < idle; i++) begin
      @(negedge clk);
      live_code = ~live_code;
      chk(out_valid == 2'b00, "R7 idle valid", int'(out_valid), 0);
      chk(out_code == held, "R7 idle hold", int'(out_code[PW-1:0]), int'(held[PW-1:0]));
    end
  endtask

  initial begin
    rst_n = 1'b0; pix_stb = 1'b0; line_start = 1'b0; tp_enable = 1'b0;
    tp_stripe_sel = 1'b0; interval_sel = 2'd0; clamp_code = 8'h50; live_code = '0;
    repeat (3) @(negedge clk);
    chk(out_valid == 2'b00, "R1 reset valid", int'(out_valid), 0);
    chk(out_code == '0, "R1 reset code", int'(out_code[PW-1:0]), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(out_valid == 2'b00, "R1 post-reset valid", int'(out_valid), 0);

    // passthrough
    for (int i = 0; i < 20; i++) px(i == 0, i % 2, "R2 passthrough");

    // stripe sweeps, with strobe gaps
    tp_enable = 1'b1; tp_stripe_sel = 1'b1;
    for (int s = 0; s < 4; s++) begin
      interval_sel = 2'(s);
      for (int i = 0; i < 140; i++) px(i == 0, (i % 3 == 0) ? 1 : 0, "R4 stripe width");
    end
    // black-level extremes
    clamp_code = 8'h00; interval_sel = 2'd1;
    for (int i = 0; i < 40; i++) px(i == 0, 0, "R3 stripe clamp 0");
    clamp_code = 8'hFF;
    for (int i = 0; i < 40; i++) px(i == 0, 0, "R3 stripe clamp 255");
    clamp_code = 8'h50;

    // gradation short lines
    tp_stripe_sel = 1'b0;
    for (int s = 1; s < 4; s++) begin
      interval_sel = 2'(s);
      for (int i = 0; i < 80; i++) px(i == 0, i % 2, "R5 ramp step");
    end
    // wrap past 4095
    interval_sel = 2'd0;
    for (int i = 0; i < 8200; i++) px(i == 0, 0, (i >= 8180) ? "R6 ramp wrap" : "R5 ramp long");

    // mid-line restart
    for (int i = 0; i < 40; i++) px(i == 0, 0, "R8 pre-restart");
    for (int i = 0; i < 12; i++) px(i == 0, 0, "R8 restart");
    tp_stripe_sel = 1'b1;
    for (int i = 0; i < 30; i++) px(i == 0, 0, "R8 stripe pre-restart");
    for (int i = 0; i < 12; i++) px(i == 0, 0, "R8 stripe restart");

    // select changes mid-line; counters keep running
    tp_stripe_sel = 1'b0;
    for (int i = 0; i < 20; i++) px(i == 0, 0, "R9 ramp part");
    tp_stripe_sel = 1'b1;
    for (int i = 0; i < 20; i++) px(1'b0, 0, "R9 stripe part");
    tp_enable = 1'b0;
    for (int i = 0; i < 5; i++) px(1'b0, 0, "R9 disabled part");
    tp_enable = 1'b1; tp_stripe_sel = 1'b0;
    for (int i = 0; i < 20; i++) px(1'b0, 0, "R9 ramp resumed");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule